// File: doc/BRIEF.md
# Segmented Address Translation Checker

This unit sits between an address generator and the memory system. It accepts one access request per handshake and returns either a physical address or a fault code. Each request carries a linear address with the segment base already added, an access size, a segment index, and flags for write and instruction fetch. The same cycle also supplies the mode bits (protection, paging, long mode active, code segment in 64-bit mode) and the selected segment's base, limit and attribute bits. The unit presents the segment index on `seg_sel` so that the surrounding logic can supply those attributes.

Unless the core runs 64-bit code in long mode, a protected-mode access is first checked against the segment's permissions and its limit. The limit check covers expand-up and expand-down segments, and also segments whose limit is numerically below their base. With paging on, the unit then looks up the page number in an external fully associative page cache. A hit gives the physical frame. A miss gives a fault code, and the code for an instruction fetch differs from the code for a data access. The result is registered, and it appears one cycle after the request is accepted.

Top module: `seg_xlate_unit`

## Requirements
- R1: With `prot_en` low, the response carries `rsp_paddr` equal to the request address and `rsp_fault` = 0, whatever the segment attributes, the paging bit and the page cache show.
- R2: With `long_act` and `cs_64` both high, no segment permission or limit check is made. If only one of them is high, the checks apply.
- R3: A write (`req_write` = 1) to a segment whose `seg_wr` is low returns `rsp_fault` = 1 (general protection) with `rsp_paddr` = 0.
- R4: A data read (`req_write` = 0, `req_exec` = 0) from a segment whose `seg_rd` is low returns fault code 1. An instruction fetch from the same segment is not refused for that reason.
- R5: Expand-up segment (`seg_expdn` = 0) with limit >= base: fault code 1 when limit < address + size.
- R6: Expand-up segment with limit < base: fault code 1 only when limit < address + size and address < base.
- R7: Expand-down segment (`seg_expdn` = 1) with limit < base: fault code 1 when address <= limit or address + size >= base.
- R8: Expand-down segment with limit >= base: fault code 1 when address <= limit and address + size >= base.
- R9: With protection and paging on and the segment checks passed, `pt_vpn` carries address bits [31:12]. On `pt_hit` the physical address is `pt_frame` OR'ed with address bits [11:0], and the fault code is 0.
- R10: A page cache miss returns fault code 2 for an instruction fetch (`req_exec` = 1) and 3 for a data access, with `rsp_paddr` = 0. Any nonzero fault code comes with `rsp_paddr` = 0.
- R11: With protection on and paging off, the request address passes through unchanged once the segment checks pass.
- R12: Address + size is formed one bit wider than the address, so an access that crosses the top of the address space does not wrap below the limit.
- R13: After reset `rsp_valid` is low and `req_ready` is high. `req_ready` = !`rsp_valid` || `rsp_ready`. The response appears one cycle after an accepted request and holds steady while `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 32 | Linear address (segment base already added) |
| req_size | input | 4 | Access size in bytes |
| req_seg | input | 3 | Segment index |
| req_write | input | 1 | Access is a write |
| req_exec | input | 1 | Access is an instruction fetch |
| prot_en | input | 1 | Protection enable |
| page_en | input | 1 | Paging enable |
| long_act | input | 1 | Long mode active |
| cs_64 | input | 1 | Code segment in 64-bit mode |
| seg_sel | output | 3 | Segment index presented for the attribute fetch |
| seg_base | input | 32 | Selected segment base |
| seg_limit | input | 32 | Selected segment limit |
| seg_wr | input | 1 | Segment writable |
| seg_rd | input | 1 | Segment readable |
| seg_expdn | input | 1 | Segment expands down |
| pt_vpn | output | 20 | Page number presented to the page cache |
| pt_hit | input | 1 | Page cache hit |
| pt_frame | input | 32 | Page frame address on a hit |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_paddr | output | 32 | Physical address |
| rsp_fault | output | 2 | 0 none, 1 general protection, 2 fetch miss, 3 data miss |

## Verification
The bench works through each of the four limit-versus-base cases with accesses just inside and just outside the allowed region. A unit that mixed up the wrapped and the ordinary forms would either raise protection faults on legal accesses or let illegal ones through. An access that straddles the top of the address space checks that the end address keeps its carry; a truncated sum would wrap to a small value and pass the limit check. Further tests cover fetches from unreadable segments, miss codes that differ between fetch and data, the long-mode bypass with only one of its two bits set, and a response held under back-pressure, where a unit that accepted anyway would overwrite an unread result.

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit #(
  parameter int AW  = 32,
  parameter int SZW = 4,
  parameter int SGW = 3,
  parameter int PGB = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic [SZW-1:0] req_size,
  input  logic [SGW-1:0] req_seg,
  input  logic           req_write,
  input  logic           req_exec,
  input  logic           prot_en,
  input  logic           page_en,
  input  logic           long_act,
  input  logic           cs_64,
  output logic [SGW-1:0] seg_sel,
  input  logic [AW-1:0]  seg_base,
  input  logic [AW-1:0]  seg_limit,
  input  logic           seg_wr,
  input  logic           seg_rd,
  input  logic           seg_expdn,
  output logic [AW-PGB-1:0] pt_vpn,
  input  logic           pt_hit,
  input  logic [AW-1:0]  pt_frame,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [AW-1:0]  rsp_paddr,
  output logic [1:0]     rsp_fault
);
  localparam int VPW = AW - PGB;
  localparam logic [1:0] FLT_NONE = 2'd0;
  localparam logic [1:0] FLT_GP   = 2'd1;
  localparam logic [1:0] FLT_IMIS = 2'd2;
  localparam logic [1:0] FLT_DMIS = 2'd3;

  logic [AW:0] span_end, lim_x, base_x;
  logic chk_on, perm_bad, lim_lo, up_bad, dn_bad, seg_bad, accept;
  logic [AW-1:0] nxt_paddr;
  logic [1:0]    nxt_fault;

  assign seg_sel   = req_seg;
  assign pt_vpn    = req_addr[AW-1:PGB];
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  assign span_end = {1'b0, req_addr} + {{(AW+1-SZW){1'b0}}, req_size};
  assign lim_x    = {1'b0, seg_limit};
  assign base_x   = {1'b0, seg_base};

  assign chk_on   = !(long_act && cs_64);
  assign perm_bad = (req_write && !seg_wr) || (!req_write && !req_exec && !seg_rd);
  assign lim_lo   = seg_limit < seg_base;
  assign up_bad   = lim_lo ? (lim_x < span_end && req_addr < seg_base)
                           : (lim_x < span_end);
  assign dn_bad   = lim_lo ? (req_addr <= seg_limit || span_end >= base_x)
                           : (req_addr <= seg_limit && span_end >= base_x);
  assign seg_bad  = chk_on && (perm_bad || (seg_expdn ? dn_bad : up_bad));

  always_comb begin
    nxt_paddr = '0;
    nxt_fault = FLT_NONE;
    if (!prot_en) begin
      nxt_paddr = req_addr;
    end else if (seg_bad) begin
      nxt_fault = FLT_GP;
    end else if (!page_en) begin
      nxt_paddr = req_addr;
    end else if (!pt_hit) begin
      nxt_fault = req_exec ? FLT_IMIS : FLT_DMIS;
    end else begin
      nxt_paddr = pt_frame | {{VPW{1'b0}}, req_addr[PGB-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= FLT_NONE;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_paddr <= nxt_paddr;
      rsp_fault <= nxt_fault;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

module seg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic        req_exec,
  input logic        prot_en,
  input logic        page_en,
  input logic        long_act,
  input logic        cs_64,
  input logic        pt_hit,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_paddr,
  input logic [1:0]  rsp_fault
);
  // R13
  hold_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));
  // R13
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);
  // R1
  real_mode_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !prot_en |=> rsp_fault == 2'd0 && rsp_paddr == $past(req_addr));
  // R10
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 2'd0 |-> rsp_paddr == 32'd0);
  // R10
  miss_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && prot_en && page_en && !pt_hit && long_act && cs_64
    |=> rsp_fault == ($past(req_exec) ? 2'd2 : 2'd3));
  // R11
  nopage_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && prot_en && !page_en && long_act && cs_64
    |=> rsp_fault == 2'd0 && rsp_paddr == $past(req_addr));
endmodule

bind seg_xlate_unit seg_xlate_chk u_chk (.*);

// File: tb/test_seg_xlate_unit.sv
module test_seg_xlate_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_size = 4'd4;
  logic [2:0]  req_seg = '0;
  logic req_write = 1'b0, req_exec = 1'b0;
  logic prot_en = 1'b0, page_en = 1'b0, long_act = 1'b0, cs_64 = 1'b0;
  logic [2:0]  seg_sel;
  logic [31:0] seg_base = '0, seg_limit = 32'hFFFF_FFFF;
  logic seg_wr = 1'b1, seg_rd = 1'b1, seg_expdn = 1'b0;
  logic [19:0] pt_vpn;
  logic pt_hit = 1'b0;
  logic [31:0] pt_frame = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  seg_xlate_unit i_seg_xlate_unit (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input string tag, input logic [31:0] addr, input logic [3:0] sz,
                       input logic wr, input logic ex,
                       input logic [31:0] exp_pa, input logic [1:0] exp_f);
    @(negedge clk);
    req_addr = addr; req_size = sz; req_write = wr; req_exec = ex; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
    check({tag, " fault"}, {30'd0, rsp_fault}, {30'd0, exp_f});
    check({tag, " paddr"}, rsp_paddr, exp_pa);
  endtask

  task automatic open_seg;
    seg_base = 32'h0; seg_limit = 32'hFFFF_FFFF; seg_expdn = 1'b0;
    seg_wr = 1'b1; seg_rd = 1'b1; long_act = 1'b0; cs_64 = 1'b0;
  endtask

  task automatic t_reset;
    check("R13 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R13 reset req_ready", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_real;
    prot_en = 0; page_en = 1; pt_hit = 0; seg_wr = 0; seg_rd = 0; seg_limit = 32'h10;
    issue("R1 real write", 32'h0012_3456, 4, 1, 0, 32'h0012_3456, 2'd0);
    issue("R1 real read", 32'h8000_0000, 4, 0, 0, 32'h8000_0000, 2'd0);
    open_seg(); page_en = 0;
  endtask

  task automatic t_perm;
    prot_en = 1; page_en = 0; open_seg();
    seg_wr = 0;
    issue("R3 write nonwritable", 32'h100, 4, 1, 0, 32'h0, 2'd1);
    seg_wr = 1; seg_rd = 0;
    issue("R4 read nonreadable", 32'h100, 4, 0, 0, 32'h0, 2'd1);
    issue("R4 fetch nonreadable", 32'h100, 4, 0, 1, 32'h100, 2'd0);
    issue("R4 write nonreadable", 32'h104, 4, 1, 0, 32'h104, 2'd0);
    open_seg();
  endtask

  task automatic t_up;
    prot_en = 1; page_en = 0; open_seg();
    seg_base = 32'h1000; seg_limit = 32'h1FFF;
    issue("R5 inside", 32'h1FF0, 4, 0, 0, 32'h1FF0, 2'd0);
    issue("R5 past limit", 32'h1FFC, 4, 0, 0, 32'h0, 2'd1);
    seg_base = 32'h8000; seg_limit = 32'h0FFF;
    issue("R6 gap", 32'h2000, 4, 0, 0, 32'h0, 2'd1);
    issue("R6 above base", 32'h9000, 4, 0, 0, 32'h9000, 2'd0);
    issue("R6 below limit", 32'h0100, 4, 0, 0, 32'h0100, 2'd0);
    open_seg();
  endtask

  task automatic t_down;
    prot_en = 1; page_en = 0; open_seg(); seg_expdn = 1;
    seg_base = 32'h8000; seg_limit = 32'h1000;
    issue("R7 at or below limit", 32'h0800, 4, 0, 0, 32'h0, 2'd1);
    issue("R7 middle", 32'h4000, 4, 0, 0, 32'h4000, 2'd0);
    issue("R7 reaches base", 32'h7FFE, 4, 0, 0, 32'h0, 2'd1);
    seg_base = 32'h1000; seg_limit = 32'h5000;
    issue("R8 inside window", 32'h2000, 4, 0, 0, 32'h0, 2'd1);
    issue("R8 above limit", 32'h6000, 4, 0, 0, 32'h6000, 2'd0);
    issue("R8 below base", 32'h0100, 4, 0, 0, 32'h0100, 2'd0);
    open_seg();
  endtask

  task automatic t_carry;
    prot_en = 1; page_en = 0; open_seg();
    issue("R12 wrap at top", 32'hFFFF_FFFE, 4, 0, 0, 32'h0, 2'd1);
  endtask

  task automatic t_long;
    prot_en = 1; page_en = 0; open_seg(); seg_wr = 0;
    long_act = 1; cs_64 = 1;
    issue("R2 bypass perm", 32'h200, 4, 1, 0, 32'h200, 2'd0);
    issue("R2 bypass limit", 32'hFFFF_FFFE, 4, 0, 0, 32'hFFFF_FFFE, 2'd0);
    long_act = 1; cs_64 = 0;
    issue("R2 cs not 64", 32'h200, 4, 1, 0, 32'h0, 2'd1);
    long_act = 0; cs_64 = 1;
    issue("R2 not long", 32'h200, 4, 1, 0, 32'h0, 2'd1);
    open_seg();
  endtask

  task automatic t_page;
    prot_en = 1; page_en = 1; open_seg();
    pt_hit = 1; pt_frame = 32'h0ABC_D000;
    @(negedge clk); req_addr = 32'h1234_5678;
    #1 check("R9 vpn", {12'd0, pt_vpn}, 32'h0001_2345);
    issue("R9 hit", 32'h1234_5678, 4, 0, 0, 32'h0ABC_D678, 2'd0);
    pt_hit = 0;
    issue("R10 fetch miss", 32'h1234_5678, 4, 0, 1, 32'h0, 2'd2);
    issue("R10 data miss", 32'h1234_5678, 4, 1, 0, 32'h0, 2'd3);
    page_en = 0;
    issue("R11 no paging", 32'h00AB_CDEF, 4, 0, 0, 32'h00AB_CDEF, 2'd0);
  endtask

  task automatic t_seg_sel;
    @(negedge clk); req_seg = 3'd5;
    #1 check("R13 seg_sel follows index", {29'd0, seg_sel}, 32'd5);
  endtask

  task automatic t_backpressure;
    prot_en = 0;
    @(negedge clk);
    rsp_ready = 0; req_addr = 32'h100; req_valid = 1;
    @(posedge clk); @(negedge clk);
    req_addr = 32'h200;
    check("R13 first result", rsp_paddr, 32'h100);
    check("R13 ready low", {31'd0, req_ready}, 32'd0);
    @(posedge clk); @(negedge clk);
    check("R13 held result", rsp_paddr, 32'h100);
    check("R13 held valid", {31'd0, rsp_valid}, 32'd1);
    rsp_ready = 1;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    check("R13 second result", rsp_paddr, 32'h200);
    @(posedge clk); @(negedge clk);
    check("R13 valid drops", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL R13 watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_real();
    t_perm();
    t_up();
    t_down();
    t_carry();
    t_long();
    t_page();
    t_seg_sel();
    t_backpressure();
    finish_run();
  end
endmodule